// File: doc/BRIEF.md
# Line Pixel Framer with Black-Level Clamp

This block sits after the converter of a linear image sensor. It takes one digitised sample per pixel period and a line-start strobe from the sensor timing logic. It counts each sample's position in the line and uses that position to sort the sample into a role: leading dummy, optical-black reference, effective pixel or trailing dummy. A line is 3066 positions long. There are 56 leading positions, then 3000 effective pixels, then 10 trailing positions. The 30 samples at positions 24 to 53 are shielded from light. Their mean becomes the black level for that line.

In normal mode, each effective pixel leaves the block with that line's black level subtracted. The result floors at zero. The output is a stream in AXI4-Stream style: a valid flag, the data, and a last flag on the final pixel of the line. Dummy positions produce no output. If a new line-start arrives before the current line is finished, the current line is dropped and a sticky error flag is set. In bypass mode, the block passes every one of the 3066 raw samples through unchanged.

Top module: `lineFramer`

## Requirements
- R1: After reset, `pixValid`, `pixLast` and `lineErr` are 0.
- R2: `lineStart` is taken only in a cycle with `sampleValid` high, and that sample is position 0. Valid samples outside a line produce no output, and neither does a `lineStart` without `sampleValid`.
- R3: In normal mode, positions 0 to 55 and 3056 to 3065 produce no output.
- R4: In normal mode, each sample at positions 56 to 3055 produces exactly one output, in order, one cycle after it is taken. A full line gives 3000 outputs.
- R5: The black level of a line is floor(sum of the samples at positions 24 to 53 / 30). It is recomputed for every line and applied to that same line's pixels.
- R6: The output data for an effective pixel is sample − level when sample > level, and 0 otherwise (including sample = level).
- R7: `pixLast` is high only together with the output for position 3055 in normal mode. Each complete line has exactly one such output.
- R8: A `lineStart` taken while a line is unfinished restarts counting at position 0. It also sets `lineErr`, which stays 1 until reset. Lines that complete normally leave `lineErr` at 0.
- R9: `bypassEn` is sampled with `lineStart` and holds for the whole line. In bypass, all 3066 samples are output unchanged after one cycle, with `pixLast` on position 3065.
- R10: Cycles with `sampleValid` low do not advance the position and do not produce output, whatever `sampleData` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| lineStart | input | 1 | Marks the current sample as position 0 of a new line |
| sampleValid | input | 1 | `sampleData` holds a sample this cycle |
| sampleData | input | 12 | Digitised sensor sample |
| bypassEn | input | 1 | Raw pass-through for the line being started |
| pixValid | output | 1 | Output sample valid |
| pixData | output | 12 | Black-corrected (or raw) sample |
| pixLast | output | 1 | Final output sample of the line |
| lineErr | output | 1 | Sticky: a line was cut short by a new start |

## Verification
The lines are run with several patterns, each aimed at a different fault:
- **Constant black reference with a ramp of pixels.** This separates a correct subtraction from an off-by-one clamp. Pixels fall below, on and above the level.
- **Black reference whose sum is not a multiple of 30.** This exposes rounding errors in the reciprocal divide.
- **Full-scale black reference.** Every pixel must clamp to zero.
- **Bypass line with gaps in `sampleValid`.** This shows that gaps neither shift positions nor leak data, and that bypass is latched per line.

Consecutive lines carry different black levels, so a stale level shows up. Directed runs cover stray samples outside a line, a line aborted mid-way, the sticky error, and reset.

// File: rtl/lineFramerPkg.sv
`timescale 1ns/1ps
package lineFramerPkg;

  // Strobes from the position control to the datapath, one sample cycle each
  typedef struct packed {
    logic clearSum;    // first sample of a line: restart the black sum
    logic accBlack;    // sample belongs to the black reference window
    logic latchLevel;  // black sum is complete: capture the mean
    logic emitEff;     // effective pixel: emit clamped difference
    logic emitRaw;     // bypass line: emit sample as-is
    logic markLast;    // emitted sample closes the line
  } framerCtl_t;

endpackage

// File: rtl/lineFramerCtl.sv
`timescale 1ns/1ps
module lineFramerCtl
  import lineFramerPkg::*;
#(
  parameter int LEAD_LEN    = 56,
  parameter int BLACK_FIRST = 24,
  parameter int BLACK_LEN   = 30,
  parameter int EFF_LEN     = 3000,
  parameter int TRAIL_LEN   = 10
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       lineStart,
  input  logic       sampleValid,
  input  logic       bypassEn,
  output framerCtl_t ctl,
  output logic       lineErr
);

  localparam int LINE_LEN = LEAD_LEN + EFF_LEN + TRAIL_LEN;
  localparam int POS_W    = $clog2(LINE_LEN + 1);

  localparam logic [POS_W-1:0] BLK_LO   = POS_W'(BLACK_FIRST);
  localparam logic [POS_W-1:0] BLK_HI   = POS_W'(BLACK_FIRST + BLACK_LEN - 1);
  localparam logic [POS_W-1:0] EFF_LO   = POS_W'(LEAD_LEN);
  localparam logic [POS_W-1:0] EFF_HI   = POS_W'(LEAD_LEN + EFF_LEN - 1);
  localparam logic [POS_W-1:0] POS_LAST = POS_W'(LINE_LEN - 1);

  logic [POS_W-1:0] posCnt;
  logic [POS_W-1:0] curPos;
  logic             inLine;
  logic             lineBypass;
  logic             levelPending;
  logic             startNow;
  logic             active;
  logic             modeBypass;
  logic             inBlack;
  logic             inEff;
  logic             atLineEnd;

  // Position of the sample presented this cycle
  assign startNow   = sampleValid & lineStart;
  assign curPos     = startNow ? '0 : posCnt;
  assign active     = sampleValid & (startNow | inLine);
  assign modeBypass = startNow ? bypassEn : lineBypass;
  assign atLineEnd  = (curPos == POS_LAST);

  assign inBlack = (curPos >= BLK_LO) && (curPos <= BLK_HI);
  assign inEff   = (curPos >= EFF_LO) && (curPos <= EFF_HI);

  always_comb begin
    ctl            = '0;
    ctl.clearSum   = startNow;
    ctl.accBlack   = active & ~modeBypass & inBlack;
    ctl.latchLevel = levelPending;
    ctl.emitEff    = active & ~modeBypass & inEff;
    ctl.emitRaw    = active & modeBypass;
    ctl.markLast   = modeBypass ? atLineEnd : (curPos == EFF_HI);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      posCnt       <= '0;
      inLine       <= 1'b0;
      lineBypass   <= 1'b0;
      levelPending <= 1'b0;
      lineErr      <= 1'b0;
    end else begin
      if (active) begin
        posCnt <= curPos + POS_W'(1);
        inLine <= ~atLineEnd;
      end
      if (startNow) begin
        lineBypass <= bypassEn;
      end
      if (startNow && inLine) begin
        lineErr <= 1'b1;
      end
      levelPending <= active & ~modeBypass & (curPos == BLK_HI);
    end
  end

  // A raised abort flag never drops while out of reset
  assert_err_sticky_R8 : assert property (@(posedge clk) disable iff (!rstN)
    lineErr |=> lineErr);

  // The running position never leaves the line while a line is open
  assert_pos_in_line_R4 : assert property (@(posedge clk) disable iff (!rstN)
    inLine |-> (posCnt <= POS_LAST));

  // A sample plays at most one role
  assert_single_role_R3 : assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ctl.accBlack, ctl.emitEff, ctl.emitRaw}));

endmodule

// File: rtl/lineFramerDp.sv
`timescale 1ns/1ps
module lineFramerDp
  import lineFramerPkg::*;
#(
  parameter int DATA_W    = 12,
  parameter int BLACK_LEN = 30
) (
  input  logic              clk,
  input  logic              rstN,
  input  framerCtl_t        ctl,
  input  logic [DATA_W-1:0] sampleData,
  output logic              pixValid,
  output logic [DATA_W-1:0] pixData,
  output logic              pixLast
);

  localparam int CNT_W = $clog2(BLACK_LEN);
  localparam int SUM_W = DATA_W + CNT_W;

  logic [SUM_W-1:0]  blackSum;
  logic [DATA_W-1:0] blackLevel;
  logic [DATA_W-1:0] levelNext;
  logic [DATA_W-1:0] clamped;
  logic              emitAny;

  // Mean of the black window: a plain shift for a power-of-two window,
  // otherwise a multiply by a rounded-up reciprocal whose error stays
  // below one quotient step over the whole sum range
  generate
    if ((BLACK_LEN & (BLACK_LEN - 1)) == 0) begin : gPow2Mean
      assign levelNext = DATA_W'(blackSum >> CNT_W);
    end else begin : gRecipMean
      localparam int SHIFT   = SUM_W + CNT_W;
      localparam int PROD_W  = SUM_W + SHIFT;
      localparam int RECIP   = ((2 ** SHIFT) + BLACK_LEN - 1) / BLACK_LEN;
      logic [PROD_W-1:0] prod;
      assign prod      = PROD_W'(blackSum) * PROD_W'(RECIP);
      assign levelNext = DATA_W'(prod >> SHIFT);
    end
  endgenerate

  assign clamped = (sampleData > blackLevel) ? (sampleData - blackLevel) : '0;
  assign emitAny = ctl.emitEff | ctl.emitRaw;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      blackSum   <= '0;
      blackLevel <= '0;
      pixValid   <= 1'b0;
      pixData    <= '0;
      pixLast    <= 1'b0;
    end else begin
      if (ctl.clearSum || ctl.accBlack) begin
        blackSum <= (ctl.clearSum ? '0 : blackSum)
                  + (ctl.accBlack ? SUM_W'(sampleData) : '0);
      end
      if (ctl.latchLevel) begin
        blackLevel <= levelNext;
      end
      pixValid <= emitAny;
      pixLast  <= emitAny & ctl.markLast;
      if (emitAny) begin
        pixData <= ctl.emitRaw ? sampleData : clamped;
      end
    end
  end

  // Last only rides on a valid output
  assert_last_has_valid_R7 : assert property (@(posedge clk) disable iff (!rstN)
    pixLast |-> pixValid);

  // Subtracting a level can only lower a pixel
  assert_clamp_not_above_R6 : assert property (@(posedge clk) disable iff (!rstN)
    ctl.emitEff |=> (pixValid && pixData <= $past(sampleData)));

  // Bypass emits the sample untouched
  assert_bypass_raw_R9 : assert property (@(posedge clk) disable iff (!rstN)
    ctl.emitRaw |=> (pixValid && pixData == $past(sampleData)));

endmodule

// File: rtl/lineFramer.sv
`timescale 1ns/1ps
module lineFramer
  import lineFramerPkg::*;
#(
  parameter int DATA_W      = 12,
  parameter int LEAD_LEN    = 56,
  parameter int BLACK_FIRST = 24,
  parameter int BLACK_LEN   = 30,
  parameter int EFF_LEN     = 3000,
  parameter int TRAIL_LEN   = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              lineStart,
  input  logic              sampleValid,
  input  logic [DATA_W-1:0] sampleData,
  input  logic              bypassEn,
  output logic              pixValid,
  output logic [DATA_W-1:0] pixData,
  output logic              pixLast,
  output logic              lineErr
);

  framerCtl_t ctlStrobes;

  lineFramerCtl #(
    .LEAD_LEN   (LEAD_LEN),
    .BLACK_FIRST(BLACK_FIRST),
    .BLACK_LEN  (BLACK_LEN),
    .EFF_LEN    (EFF_LEN),
    .TRAIL_LEN  (TRAIL_LEN)
  ) u_ctl (
    .clk        (clk),
    .rstN       (rstN),
    .lineStart  (lineStart),
    .sampleValid(sampleValid),
    .bypassEn   (bypassEn),
    .ctl        (ctlStrobes),
    .lineErr    (lineErr)
  );

  lineFramerDp #(
    .DATA_W   (DATA_W),
    .BLACK_LEN(BLACK_LEN)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctlStrobes),
    .sampleData(sampleData),
    .pixValid  (pixValid),
    .pixData   (pixData),
    .pixLast   (pixLast)
  );

endmodule

// File: tb/lineFramer_tb.sv
`timescale 1ns/1ps
module lineFramer_tb;

  localparam int DW    = 12;
  localparam int LEAD  = 56;
  localparam int BF    = 24;
  localparam int BL    = 30;
  localparam int EFF   = 3000;
  localparam int TRAIL = 10;
  localparam int LINE  = LEAD + EFF + TRAIL;
  localparam int NVEC  = 5;

  // Per line: black base, black spread, pixel base, pixel step, bypass, gap period
  localparam int VEC [NVEC][6] = '{
    '{200,  1,    0, 3, 0, 0},  // constant level, ramp crossing it
    '{100, 29, 4000, 0, 0, 5},  // uneven black sum, gaps
    '{4095, 1,    0, 5, 0, 0},  // full-scale black: all clamp
    '{0,    1,    7, 1, 1, 3},  // bypass with gaps
    '{60,   1,    0, 1, 0, 0}   // pixels equal to the level
  };

  logic          clk = 1'b0;
  logic          rstN;
  logic          lineStart;
  logic          sampleValid;
  logic [DW-1:0] sampleData;
  logic          bypassEn;
  logic          pixValid;
  logic [DW-1:0] pixData;
  logic          pixLast;
  logic          lineErr;

  int checks = 0;
  int errors = 0;

  // Reference model state
  bit            expV;
  logic [DW-1:0] expD;
  bit            expL;
  string         expTag;
  int            mPos;
  bit            mIn;
  bit            mByp;
  int            mSum;
  int            mLevel;
  int            outCount;
  int            lastCount;

  always #2.5 clk = ~clk;

  lineFramer u_dut (
    .clk        (clk),
    .rstN       (rstN),
    .lineStart  (lineStart),
    .sampleValid(sampleValid),
    .sampleData (sampleData),
    .bypassEn   (bypassEn),
    .pixValid   (pixValid),
    .pixData    (pixData),
    .pixLast    (pixLast),
    .lineErr    (lineErr)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] sampleVal(input int row, input int pos);
    int v;
    if (pos >= BF && pos < BF + BL) v = VEC[row][0] + (pos * 7) % VEC[row][1];
    else v = (VEC[row][2] + pos * VEC[row][3]) % 4096;
    if (v > 4095) v = 4095;
    return DW'(v);
  endfunction

  // One cycle: compare the output of the previous sample, then drive the next
  task automatic stepCycle(input bit vld, input bit st, input logic [DW-1:0] d, input bit byp);
    int p;
    bit act;
    @(negedge clk);
    if (expV || pixValid) begin
      checks++;
      if (pixValid !== expV || (expV && (pixData !== expD || pixLast !== expL))) begin
        errors++;
        $display("FAIL %s: valid/data/last actual %0b/%0d/%0b expected %0b/%0d/%0b",
                 expTag, pixValid, pixData, pixLast, expV, expD, expL);
      end
    end
    if (pixValid) outCount++;
    if (pixValid && pixLast) lastCount++;
    sampleValid = vld;
    lineStart   = st;
    sampleData  = d;
    bypassEn    = byp;
    expV = 0; expL = 0; expD = '0;
    expTag = vld ? "R2" : "R10";
    if (vld) begin
      if (st) begin
        p = 0; act = 1; mByp = byp; mSum = 0;
      end else begin
        p = mPos; act = mIn;
      end
      if (act) begin
        expTag = "R3";
        if (mByp) begin
          expV = 1; expD = d; expL = (p == LINE - 1); expTag = "R9";
        end else begin
          if (p >= BF && p < BF + BL) begin
            mSum += int'(d);
            if (p == BF + BL - 1) mLevel = mSum / BL;
          end
          if (p >= LEAD && p < LEAD + EFF) begin
            expV = 1;
            expD = (int'(d) > mLevel) ? DW'(int'(d) - mLevel) : '0;
            expL = (p == LEAD + EFF - 1);
            expTag = expL ? "R7 R6 R5" : "R4 R6 R5";
          end
        end
        mPos = p + 1;
        mIn  = (p != LINE - 1);
      end
    end
  endtask

  task automatic runLine(input int row, input int upTo);
    int gap;
    gap = VEC[row][5];
    stepCycle(0, 0, 12'h5A5, 0);
    stepCycle(0, 0, 12'h5A5, 0);
    outCount = 0; lastCount = 0;
    for (int pos = 0; pos < upTo; pos++) begin
      if (gap > 0 && pos % gap == 0) stepCycle(0, 0, 12'hABC, 1'(VEC[row][4]));  // R10 gap
      stepCycle(1, pos == 0, sampleVal(row, pos), 1'(VEC[row][4]));
    end
  endtask

  task automatic finishLine(input int row);
    stepCycle(0, 0, '0, 0);
    stepCycle(0, 0, '0, 0);
    check(outCount == (VEC[row][4] != 0 ? LINE : EFF), "R4 output count", outCount,
          VEC[row][4] != 0 ? LINE : EFF);
    check(lastCount == 1, "R7 last count", lastCount, 1);
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 0; lineStart = 0; sampleValid = 0; sampleData = '0; bypassEn = 0;
    repeat (3) @(negedge clk);
    expV = 0; mIn = 0; mPos = 0; mSum = 0; mLevel = 0; mByp = 0;
    rstN = 1;
  endtask

  initial begin
    #750000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rstN = 0; lineStart = 0; sampleValid = 0; sampleData = '0; bypassEn = 0;
    doReset();
    @(negedge clk);
    check(pixValid == 0, "R1 pixValid after reset", int'(pixValid), 0);
    check(pixLast == 0, "R1 pixLast after reset", int'(pixLast), 0);
    check(lineErr == 0, "R1 lineErr after reset", int'(lineErr), 0);

    // R2: start strobe without a valid sample, then stray samples
    outCount = 0;
    stepCycle(0, 1, 12'd300, 0);
    for (int i = 0; i < 80; i++) stepCycle(1, 0, DW'(i * 50), 0);
    stepCycle(0, 0, '0, 0);
    check(outCount == 0, "R2 no output outside a line", outCount, 0);

    // Table of line patterns
    for (int row = 0; row < NVEC; row++) begin
      runLine(row, LINE);
      finishLine(row);
      for (int i = 0; i < 5; i++) stepCycle(1, 0, 12'hFFF, 0);  // R2 stray samples
    end
    check(lineErr == 0, "R8 no error after complete lines", int'(lineErr), 0);

    // R8: abort a line mid-way, then a full line restarts at position 0
    runLine(0, 100);
    runLine(4, LINE);
    finishLine(4);
    check(lineErr == 1, "R8 error after abort", int'(lineErr), 1);
    for (int i = 0; i < 20; i++) stepCycle(0, 0, '0, 0);
    check(lineErr == 1, "R8 error stays set", int'(lineErr), 1);

    // R1: reset clears the sticky flag
    doReset();
    @(negedge clk);
    check(lineErr == 0, "R1 lineErr cleared by reset", int'(lineErr), 0);
    check(pixValid == 0, "R1 pixValid after second reset", int'(pixValid), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule